// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block collects up to 64 interrupt sources into a single request line for a processor. Each source owns one bit in a pair of 32-bit mask words and one bit in a pair of 32-bit pending words. The placement of those bits follows a fixed, non-linear map that differs per source range. Internal sources are always active-low levels. Two ranges have a programmable sense. The external lines (sources 19 to 25) choose between falling-edge capture and active-low level. The port pins (sources 48 to 63) choose between falling-edge-only capture and capture on both edges.

Software reaches the block through a small synchronous register bus with address, write enable, write data and combinational read data. It enables sources through the mask words and acknowledges captured edges by writing ones to the pending words. It reads the vector word to learn which enabled, pending source has the smallest number. That number sits in bits 31:26. A vector of zero means nothing needs service, so source 0 can never request.

Top module: `pic_vector_ctrl`

## Requirements
- R1: The mapping from source number s to (word, bit) is as follows, where word 0 is the "high" register and word 1 is the "low" register. s 0..15 maps to word 1, bit (16 − s) for s ≥ 1 and bit 0 for s = 0. s 16..18 maps to word 0, bit (18 − s). s 19..30 maps to word 0, bit (33 − s). s 31 maps to word 0, bit 15. s 32..47 maps to word 1, bit (63 − s). s 48..63 maps to word 0, bit (s − 32).
- R2: Both mask words read 0 after reset. A mask bit of 1 lets its source drive the vector and the request, and a 0 blocks it.
- R3: Internal sources (every source outside 19..25 and 48..63) are active-low levels. Their pending bit is 1 exactly while the input is low, and writing 1 to it does not clear it.
- R4: For source s in 19..25, edge-select bit (33 − s) chooses the sense. A 1 captures a falling edge into a sticky pending bit. A 0 makes the source an active-low level.
- R5: For source s in 48..63, edge-select bit (s − 32) chooses the sense. A 1 captures falling edges only, and a 0 captures both rising and falling edges. The result always goes into a sticky pending bit.
- R6: A captured edge stays pending until software writes 1 to its bit in the matching pending word. Writing 0 leaves it unchanged, and writing all ones clears every captured edge.
- R7: The vector word holds, in bits 31:26, the smallest source number in 1..63 that is both pending and enabled. All other bits read 0, and the field is 0 when no such source exists.
- R8: irq_req is 1 exactly when the vector field is non-zero.
- R9: The register offsets are 0x00 mask high, 0x04 mask low, 0x08 pending high, 0x0C pending low, 0x10 edge select and 0x14 vector. Only edge-select bits 31..16 and 14..8 are stored, so writing all ones reads back 0xFFFF7F00. Any other offset reads 0.
- R10: Source 0 shows in pending-low bit 0 and mask-low bit 0, but it never sets the vector or irq_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_raw | input | 64 | Raw asynchronous source inputs, idle high |
| irq_req | output | 1 | Request to the processor |

## Verification
The hardest state to reach from the ports is a captured edge whose source no longer shows the event. Getting there takes an edge that reaches the synchronizer, followed by a change of sense mode or a partial acknowledge. The bench keeps its own model of every sticky capture and changes raw inputs only in steps spaced far enough apart for each step to be seen. Random raw flips are mixed with random mask, edge-select and acknowledge writes, so captures build up, get switched between modes and are cleared in partial patterns. Directed steps add the both-edge port case, a level that ignores acknowledge, and two sources competing for the vector.

// File: rtl/pic_pkg.sv
// Package: shared constants and the source map of the interrupt controller.
// Assumes exactly 64 sources spread over two 32-bit register words.
package pic_pkg;

    localparam int NUM_SRC = 64;
    localparam int WORD_W  = 32;
    localparam int ID_W    = $clog2(NUM_SRC);

    // Register byte offsets
    localparam int ADR_MASK_HI = 'h00;
    localparam int ADR_MASK_LO = 'h04;
    localparam int ADR_PEND_HI = 'h08;
    localparam int ADR_PEND_LO = 'h0C;
    localparam int ADR_SENSE   = 'h10;
    localparam int ADR_VECTOR  = 'h14;

    // Edge-select bits that exist (31..16 and 14..8)
    localparam logic [WORD_W-1:0] SENSE_IMPL = 32'hFFFF_7F00;

    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'd0,
        SRC_EXTLINE  = 2'd1,
        SRC_PORTPIN  = 2'd2
    } src_class_e;

    // Register word (0 = high, 1 = low) that holds a source
    function automatic int map_word(int s);
        if (s < 16)      return 1;
        else if (s < 32) return 0;
        else if (s < 48) return 1;
        else             return 0;
    endfunction

    // Bit position of a source inside its word
    function automatic int map_bit(int s);
        if (s == 0)      return 0;
        else if (s < 16) return 16 - s;
        else if (s < 19) return 18 - s;
        else if (s < 31) return 33 - s;
        else if (s == 31) return 15;
        else if (s < 48) return 63 - s;
        else             return s - 32;
    endfunction

    // Sense class of a source
    function automatic src_class_e class_of(int s);
        if (s >= 19 && s <= 25)      return SRC_EXTLINE;
        else if (s >= 48 && s <= 63) return SRC_PORTPIN;
        else                         return SRC_INTERNAL;
    endfunction

    // Edge-select bit of a source (0 for internal, which never stores it)
    function automatic int sense_bit(int s);
        if (s >= 19 && s <= 25)      return 33 - s;
        else if (s >= 48 && s <= 63) return s - 32;
        else                         return 0;
    endfunction

endpackage

// File: rtl/pic_src_cell.sv
// Module: one interrupt source. It synchronizes the raw input, detects
// edges and produces the pending bit for its sense class.
// Assumes an idle-high input; the synchronizer resets to 1 so that reset
// release never fakes an edge. SYNC_STAGES must be at least 2.
module pic_src_cell #(
    parameter pic_pkg::src_class_e CLS = pic_pkg::SRC_INTERNAL,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic edge_sel_i,
    input  logic clr_i,
    output logic pend_o
);
    localparam bit IS_PORT = (CLS == pic_pkg::SRC_PORTPIN);
    localparam bit IS_EXT  = (CLS == pic_pkg::SRC_EXTLINE);

    logic [SYNC_STAGES-1:0] sync_q;
    logic prev_q;
    logic latch_q;
    logic cur, fall, rise, edge_mode, evt;

    // Shift the raw input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Keep the previous synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= cur;
    end

    // Decide the mode and which events count
    always_comb begin
        cur       = sync_q[SYNC_STAGES-1];
        fall      = prev_q & ~cur;
        rise      = ~prev_q & cur;
        edge_mode = IS_PORT | (IS_EXT & edge_sel_i);
        if (IS_PORT)     evt = edge_sel_i ? fall : (fall | rise);
        else if (IS_EXT) evt = edge_sel_i & fall;
        else             evt = 1'b0;
    end

    // Sticky capture: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= 1'b0;
        else if (!edge_mode) latch_q <= 1'b0;
        else if (evt)        latch_q <= 1'b1;
        else if (clr_i)      latch_q <= 1'b0;
    end

    // Edge modes report the capture, level mode reports the low input
    assign pend_o = edge_mode ? latch_q : ~cur;

    a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && latch_q && !clr_i) |=> latch_q);

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr_i && !evt) |=> !latch_q);

endmodule

// File: rtl/pic_prio_enc.sv
// Module: fixed-priority encoder with a registered result. The lowest set
// request index wins. The caller keeps index 0 clear when 0 means "none".
module pic_prio_enc #(
    parameter int N    = 64,
    parameter int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    output logic [ID_W-1:0] id_o,
    output logic            any_o
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [ID_W-1:0] id_c;
    logic            any_c;

    // Scan from the top so the lowest set index is the one that remains
    always_comb begin
        id_c  = '0;
        any_c = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                id_c  = ID_W'(i);
                any_c = 1'b1;
            end
        end
    end

    // Register the winner every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_o  <= '0;
            any_o <= 1'b0;
        end else begin
            id_o  <= id_c;
            any_o <= any_c;
        end
    end

    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_c |-> (req_i[id_c] && ((req_i & ((ONE << id_c) - ONE)) == '0)));

endmodule

// File: rtl/pic_vector_ctrl.sv
// Module: top of the vectored interrupt controller. It holds the mask and
// edge-select registers, maps the sources onto the register words, decodes
// acknowledge writes and presents the vector and the request line.
// Assumes a single-cycle write strobe and combinational reads.
module pic_vector_ctrl #(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [pic_pkg::WORD_W-1:0]   bus_wdata,
    output logic [pic_pkg::WORD_W-1:0]   bus_rdata,
    input  logic [pic_pkg::NUM_SRC-1:0]  src_raw,
    output logic                         irq_req
);
    import pic_pkg::*;

    localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(ADR_MASK_HI);
    localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(ADR_MASK_LO);
    localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(ADR_PEND_HI);
    localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(ADR_PEND_LO);
    localparam logic [ADDR_W-1:0] A_SENSE   = ADDR_W'(ADR_SENSE);
    localparam logic [ADDR_W-1:0] A_VECTOR  = ADDR_W'(ADR_VECTOR);

    logic [1:0][WORD_W-1:0] mask_q;
    logic [WORD_W-1:0]      sense_q;
    logic [1:0][WORD_W-1:0] pend_w;
    logic [NUM_SRC-1:0]     pend_s;
    logic [NUM_SRC-1:0]     act_s;
    logic [ID_W-1:0]        vec_id;
    logic                   vec_any;

    // Software-written mask and edge-select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            sense_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_MASK_HI) mask_q[0] <= bus_wdata;
            if (bus_addr == A_MASK_LO) mask_q[1] <= bus_wdata;
            if (bus_addr == A_SENSE)   sense_q   <= bus_wdata & SENSE_IMPL;
        end
    end

    // One cell per source, placed on its mapped word and bit
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int W  = map_word(s);
        localparam int B  = map_bit(s);
        localparam int SB = sense_bit(s);
        localparam logic [ADDR_W-1:0] A_ACK = (W == 0) ? A_PEND_HI : A_PEND_LO;

        logic clr;
        assign clr = bus_we && (bus_addr == A_ACK) && bus_wdata[B];

        pic_src_cell #(
            .CLS         (class_of(s)),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_i      (src_raw[s]),
            .edge_sel_i (sense_q[SB]),
            .clr_i      (clr),
            .pend_o     (pend_s[s])
        );

        assign pend_w[W][B] = pend_s[s];
        if (s == 0) begin : g_reserved
            assign act_s[s] = 1'b0;
        end else begin : g_live
            assign act_s[s] = pend_s[s] & mask_q[W][B];
        end
    end

    pic_prio_enc #(
        .N    (NUM_SRC),
        .ID_W (ID_W)
    ) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (act_s),
        .id_o  (vec_id),
        .any_o (vec_any)
    );

    assign irq_req = vec_any;

    // Read multiplexer; unused offsets read zero
    always_comb begin
        case (bus_addr)
            A_MASK_HI: bus_rdata = mask_q[0];
            A_MASK_LO: bus_rdata = mask_q[1];
            A_PEND_HI: bus_rdata = pend_w[0];
            A_PEND_LO: bus_rdata = pend_w[1];
            A_SENSE:   bus_rdata = sense_q;
            A_VECTOR:  bus_rdata = {vec_id, {(WORD_W-ID_W){1'b0}}};
            default:   bus_rdata = '0;
        endcase
    end

    a_r8_irq_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (vec_id != '0));

    a_r10_src0_silent: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vec_id != '0));

    a_r9_sense_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SENSE) |-> ((bus_rdata & ~SENSE_IMPL) == '0));

endmodule

// File: tb/pic_vector_ctrl_bench.sv
`timescale 1ns/1ps
module pic_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_raw = '1;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0]      m_raw = '1;
    logic [63:0]      m_latch = '0;
    logic [1:0][31:0] m_mask = '0;
    logic [31:0]      m_sense = '0;

    always #2 clk = ~clk;

    pic_vector_ctrl u_pic_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_raw(src_raw),
        .irq_req(irq_req)
    );

    // Source map, written from R1
    function automatic int bw(int s);
        return ((s < 16) || (s >= 32 && s < 48)) ? 1 : 0;
    endfunction
    function automatic int bb(int s);
        if (s == 0) return 0;
        if (s < 16) return 16 - s;
        if (s < 19) return 18 - s;
        if (s < 31) return 33 - s;
        if (s == 31) return 15;
        if (s < 48) return 63 - s;
        return s - 32;
    endfunction
    function automatic bit is_ext(int s);  return s >= 19 && s <= 25; endfunction
    function automatic bit is_port(int s); return s >= 48; endfunction
    function automatic bit edge_mode(int s);
        if (is_port(s)) return 1'b1;
        if (is_ext(s))  return m_sense[33 - s];
        return 1'b0;
    endfunction
    function automatic bit m_pend(int s);
        return edge_mode(s) ? m_latch[s] : ~m_raw[s];
    endfunction
    function automatic logic [31:0] exp_pword(int w);
        logic [31:0] v = '0;
        for (int s = 0; s < 64; s++) if (bw(s) == w) v[bb(s)] = m_pend(s);
        return v;
    endfunction
    function automatic int exp_vec();
        for (int s = 1; s < 64; s++)
            if (m_pend(s) && m_mask[bw(s)][bb(s)]) return s;
        return 0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_raw(logic [63:0] nv);
        for (int s = 0; s < 64; s++) begin
            if (edge_mode(s)) begin
                if (is_port(s) && !m_sense[s - 32]) begin
                    if (m_raw[s] != nv[s]) m_latch[s] = 1'b1;
                end else if (m_raw[s] && !nv[s]) m_latch[s] = 1'b1;
            end
        end
        m_raw = nv;
        @(negedge clk);
        src_raw = nv;
        repeat (8) @(negedge clk);
    endtask

    task automatic set_mask(int w, logic [31:0] v);
        m_mask[w] = v;
        bus_write(w == 0 ? 5'h00 : 5'h04, v);
    endtask

    task automatic set_sense(logic [31:0] v);
        m_sense = v & 32'hFFFF_7F00;
        for (int s = 19; s <= 25; s++) if (!edge_mode(s)) m_latch[s] = 1'b0;
        bus_write(5'h10, v);
    endtask

    task automatic ack(int w, logic [31:0] v);
        for (int s = 0; s < 64; s++)
            if (bw(s) == w && v[bb(s)] && edge_mode(s)) m_latch[s] = 1'b0;
        bus_write(w == 0 ? 5'h08 : 5'h0C, v);
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        repeat (3) @(negedge clk);
        bus_read(5'h08, d); check({tag, " R1/R3/R4/R5 pend hi"}, d, exp_pword(0));
        bus_read(5'h0C, d); check({tag, " R1/R3/R4/R5 pend lo"}, d, exp_pword(1));
        bus_read(5'h14, d); check({tag, " R7 vector"}, d, {6'(exp_vec()), 26'b0});
        check({tag, " R8 irq"}, {31'b0, irq_req}, {31'b0, exp_vec() != 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = $urandom(32'd7321);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset state
        bus_read(5'h00, d); check("R2 mask hi reset", d, 0);
        bus_read(5'h04, d); check("R2 mask lo reset", d, 0);
        bus_read(5'h10, d); check("R9 sense reset", d, 0);
        check_all("reset");

        // R9 implemented edge-select bits and unused offsets
        bus_write(5'h10, 32'hFFFF_FFFF);
        bus_read(5'h10, d); check("R9 sense readback", d, 32'hFFFF_7F00);
        bus_read(5'h18, d); check("R9 unused offset", d, 0);
        bus_read(5'h1C, d); check("R9 unused offset 1C", d, 0);
        set_sense(32'h0);

        // R2: blocked source does not request
        set_raw(~(64'h1 << 5));
        check_all("R2 masked");
        set_mask(0, 32'hFFFF_FFFF);
        set_mask(1, 32'hFFFF_FFFF);
        bus_read(5'h0C, d); check("R1 src5 low-word bit 11", d, 32'h0000_0800);
        check_all("R1 src5");
        set_raw('1);

        // R3: level ignores acknowledge
        set_raw(~(64'h1 << 40));
        ack(1, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        bus_read(5'h0C, d); check("R3 level survives ack", d, 32'h0080_0000);
        set_raw('1);
        check_all("R3 released");

        // R4/R6: external line falling-edge capture then acknowledge
        set_sense(32'h0000_2000);
        set_raw(~(64'h1 << 20));
        set_raw('1);
        bus_read(5'h08, d); check("R4 edge captured", d, 32'h0000_2000);
        check_all("R4 edge");
        ack(0, 32'h0000_0000);
        bus_read(5'h08, d); check("R6 zero write keeps", d, 32'h0000_2000);
        ack(0, 32'h0000_2000);
        repeat (2) @(negedge clk);
        bus_read(5'h08, d); check("R6 w1c clears", d, 0);
        set_sense(32'h0);
        set_raw(~(64'h1 << 20));
        check_all("R4 level");
        set_raw('1);

        // R5: port pin both edges, then falling only
        set_raw(~(64'h1 << 50));
        ack(0, 32'hFFFF_FFFF);
        set_raw('1);
        bus_read(5'h08, d); check("R5 rising captured", d, 32'h0004_0000);
        ack(0, 32'hFFFF_FFFF);
        set_sense(32'h0004_0000);
        set_raw(~(64'h1 << 50));
        ack(0, 32'hFFFF_FFFF);
        set_raw('1);
        bus_read(5'h08, d); check("R5 rising ignored", d, 0);
        check_all("R5");
        set_sense(32'h0);

        // R7 priority between two sources
        set_raw(~((64'h1 << 3) | (64'h1 << 60)));
        check_all("R7 pair");
        set_mask(1, 32'hFFFF_FFFF & ~(32'h1 << 13));
        check_all("R7 low masked");
        set_mask(1, 32'hFFFF_FFFF);
        ack(0, 32'hFFFF_FFFF);
        set_raw('1);
        ack(0, 32'hFFFF_FFFF);

        // R10 source 0 never requests
        set_raw(~64'h1);
        bus_read(5'h0C, d); check("R10 src0 pending bit", d, 32'h1);
        check("R10 no irq", {31'b0, irq_req}, 0);
        set_raw('1);
        check_all("R10");

        // Random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            op = $urandom % 5;
            case (op)
                0, 1: set_raw(m_raw ^ ({$urandom, $urandom} & {$urandom, $urandom}
                                      & {$urandom, $urandom}));
                2: set_mask($urandom % 2, $urandom);
                3: set_sense($urandom);
                default: ack($urandom % 2, ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom);
            endcase
            check_all("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule